// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a system against runaway software. A hidden 16-bit up-counter advances on one of two tick enables. A two-bit field chooses which counter bit marks the end of an interval. In watchdog mode, the end of an interval raises a one-cycle reset request. In interval mode, it sets an interrupt flag and the counter keeps running. Software cannot see the counter. It controls the timer only through one 16-bit control word.

Every write carries a key in the upper byte. The write is accepted only when that key is 0x5A. A write with any other key raises the reset request at once. Reads return the byte 0x69 in the upper half and the stored control byte in the lower half. When a reset request is raised, the block returns its own control byte and counter to their reset values. The rest of the system is expected to act on the request.

Control byte layout (bit 7 to bit 0): hold, NMI edge, NMI select, interval mode, counter clear, tick select, and interval select (two bits). The two NMI bits are storage only.

Top module: `wdg_guard`

## Requirements
- R1: While rst_n is low and after its release, rd_data reads 0x6900 and both rst_req and irq are 0. This means watchdog mode, tick A and the longest interval.
- R2: rd_data[15:8] always reads 0x69. rd_data[7:0] reads the stored control byte.
- R3: A write with wr_data[15:8] = 0x5A stores wr_data[7:0], with bit 3 forced to 0. The new value can be read back from the cycle after the write.
- R4: A write with any other upper byte sets rst_req for exactly one cycle, starting in the cycle after the write. It also returns the control byte to 0x00 and the counter to 0.
- R5: Interval select (bits 1:0) picks a counter tap: 00 is bit 15, 01 is bit 13, 10 is bit 9 and 11 is bit 6. An interval ends when the selected bit goes from 0 to 1, which first happens 2^tap ticks after the counter was cleared.
- R6: In watchdog mode (bit 4 = 0), the end of an interval sets rst_req for one cycle. It also returns the control byte to 0x00 and the counter to 0.
- R7: In interval mode (bit 4 = 1), the end of an interval sets irq and never rst_req. The counter keeps running, so later interval ends come every 2^(tap+1) ticks.
- R8: A one-cycle pulse on irq_clr clears irq.
- R9: Hold (bit 7 = 1) freezes the counter.
- R10: A valid write with bit 3 = 1 sets the counter to 0. Bit 3 always reads back as 0.
- R11: Tick select (bit 2) makes the counter advance on tick_a when it is 0 and on tick_b when it is 1. The tick that is not selected has no effect.
- R12: The NMI bits (bits 6 and 5) are stored and can be read back. They do not change the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Write data: key in the upper byte, control byte in the lower byte |
| rd_data | output | 16 | Read key 0x69 and the stored control byte |
| tick_a | input | 1 | Count enable used when tick select is 0 |
| tick_b | input | 1 | Count enable used when tick select is 1 |
| irq_clr | input | 1 | Clears the interval interrupt flag |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interval interrupt flag |

## Verification
The bench counts the exact number of ticks to each interval end, for all four taps and in both modes. An off-by-one tap decode or a level-based end test would show up as a wrong count or as repeated events. It times the second interrupt after a clear, to show that the counter keeps running instead of restarting. A design that reset the counter on an interrupt would report half the period. Random keys other than 0x5A must each raise exactly one reset pulse. A design that ignored a bad key, or held the request high, would fail there. Hold, tick select and the clear bit are each checked by resuming the count and confirming that the full interval is still left.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic       hold;
    logic       nmi_edge;
    logic       nmi_sel;
    logic       itv_mode;
    logic       cnt_clr;
    logic       tick_sel;
    logic [1:0] itv_sel;
  } wdg_ctl_t;

  localparam wdg_ctl_t CTL_RST = '0;

  // Counter bit whose rising edge ends an interval.
  function automatic int unsigned tap_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 15;
      2'd1:    return 13;
      2'd2:    return 9;
      default: return 6;
    endcase
  endfunction

  // True when the next increment turns the tap bit from 0 to 1.
  function automatic logic tap_rise(input logic [CNT_W-1:0] c, input int unsigned tap);
    logic [CNT_W-1:0] m;
    m = ({{(CNT_W-1){1'b0}}, 1'b1} << tap) - {{(CNT_W-1){1'b0}}, 1'b1};
    return !c[tap] && ((c & m) == m);
  endfunction
endpackage

// File: rtl/wdg_keycheck.sv
module wdg_keycheck #(
  parameter logic [7:0] KEY = 8'h5A
) (
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic        wr_ok,
  output logic        wr_bad
);
  always_comb begin
    wr_ok  = wr_en && (wr_data[15:8] == KEY);
    wr_bad = wr_en && (wr_data[15:8] != KEY);
  end
endmodule

// File: rtl/wdg_ctl_reg.sv
module wdg_ctl_reg
  import wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_ok,
  input  wdg_ctl_t wr_ctl,
  input  logic     sys_clr,
  output wdg_ctl_t ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= CTL_RST;
    end else if (sys_clr) begin
      ctl <= CTL_RST;
    end else if (wr_ok) begin
      ctl         <= wr_ctl;
      ctl.cnt_clr <= 1'b0;
    end
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             sys_clr,
  input  logic [1:0]       itv_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  int unsigned tap;

  always_comb begin
    tap    = tap_of(itv_sel);
    expire = run && tap_rise(cnt, tap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (sys_clr || clr) cnt <= '0;
    else if (run)            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter logic [7:0] WR_KEY = 8'h5A,
  parameter logic [7:0] RD_KEY = 8'h69
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        tick_a,
  input  logic        tick_b,
  input  logic        irq_clr,
  output logic        rst_req,
  output logic        irq
);
  logic             key_ok;
  logic             key_bad;
  logic             expire;
  logic             wd_fire;
  logic             sys_clr;
  logic             run;
  logic [CNT_W-1:0] cnt;
  wdg_ctl_t         ctl;

  wdg_keycheck #(.KEY(WR_KEY)) u_key (
    .wr_en(wr_en), .wr_data(wr_data), .wr_ok(key_ok), .wr_bad(key_bad)
  );

  wdg_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ok(key_ok), .wr_ctl(wdg_ctl_t'(wr_data[7:0])),
    .sys_clr(sys_clr), .ctl(ctl)
  );

  always_comb begin
    run     = !ctl.hold && (ctl.tick_sel ? tick_b : tick_a);
    wd_fire = expire && !ctl.itv_mode;
    sys_clr = key_bad || wd_fire;
    rd_data = {RD_KEY, ctl};
  end

  wdg_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(key_ok && wr_data[3]),
    .sys_clr(sys_clr), .itv_sel(ctl.itv_sel), .cnt(cnt), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rst_req <= sys_clr;
      if (sys_clr)                     irq <= 1'b0;
      else if (expire && ctl.itv_mode) irq <= 1'b1;
      else if (irq_clr)                irq <= 1'b0;
    end
  end
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
  parameter logic [7:0] WR_KEY = 8'h5A,
  parameter logic [7:0] RD_KEY = 8'h69
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        irq_clr,
  input logic        rst_req,
  input logic        irq,
  input logic        key_ok,
  input logic        expire,
  input logic [15:0] cnt
);
  AST_BAD_KEY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:8] != WR_KEY) |=> rst_req); // R4
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !wr_en) |=> !rst_req); // R6
  AST_RST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == 16'd0 && rd_data == {RD_KEY, 8'h00})); // R6
  AST_READ_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:8] == RD_KEY); // R2
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[3]); // R10
  AST_IRQ_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rd_data[4] && !(wr_en && !key_ok)) |=> (irq && !rst_req)); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_clr && !expire) |=> !irq); // R8
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !wr_en) |=> $stable(cnt)); // R9
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ok && wr_data[3] && !(expire && !rd_data[4])) |=> cnt == 16'd0); // R10
endmodule

bind wdg_guard wdg_guard_chk #(.WR_KEY(WR_KEY), .RD_KEY(RD_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .irq_clr(irq_clr), .rst_req(rst_req), .irq(irq), .key_ok(key_ok),
  .expire(expire), .cnt(cnt)
);

// File: tb/sim_wdg_guard.sv
module sim_wdg_guard;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 70000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic        tick_a = 1'b1;
  logic        tick_b = 1'b0;
  logic        irq_clr = 1'b0;
  logic        rst_req;
  logic        irq;

  int checks = 0;
  int errors = 0;

  wdg_guard u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tick_a(tick_a), .tick_b(tick_b), .irq_clr(irq_clr), .rst_req(rst_req), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int period_of(input logic [1:0] s);
    int bits[4] = '{15, 13, 9, 6};
    return 1 << bits[s];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic wait_evt(input bit want_rst, output int j, output bit stray);
    j = 0; stray = 0;
    while (!(want_rst ? rst_req : irq) && j < LIMIT) begin
      @(negedge clk);
      j++;
      if (!want_rst && rst_req) stray = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int j;
    bit stray;
    logic [7:0] b;
    void'($urandom(32'd7321));

    // R1 reset state
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R1 rd_data", rd_data, 16'h6900);
    check("R1 rst_req", rst_req, 0);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;

    // R1/R5/R6 default watchdog: longest interval
    wait_evt(1, j, stray);
    check("R6 default expiry ticks", j, period_of(2'd0));
    check("R6 ctl after reset req", rd_data, 16'h6900);
    @(negedge clk);
    check("R6 rst_req one cycle", rst_req, 0);

    // R2/R3/R10/R12 random valid writes with hold set
    for (int i = 0; i < 16; i++) begin
      b = 8'($urandom) | 8'h80;
      wr({8'h5A, b});
      check("R3 R12 readback", rd_data, {8'h69, b & 8'hF7});
      check("R2 key byte", rd_data[15:8], 8'h69);
    end

    // R4 random bad keys
    for (int i = 0; i < 6; i++) begin
      b = 8'($urandom);
      if (b == 8'h5A) b = 8'h00;
      wr({b, 8'hB3});
      check("R4 rst_req", rst_req, 1);
      check("R4 ctl reset", rd_data, 16'h6900);
      @(negedge clk);
      check("R4 rst_req pulse", rst_req, 0);
    end

    // R5 R7 R8 interval mode each tap (NMI bits set to show R12 no effect)
    for (int s = 0; s < 4; s++) begin
      wr({8'h5A, 8'h78 | 8'(s)});
      wait_evt(0, j, stray);
      check("R5 R7 first interval", j, period_of(2'(s)));
      check("R7 no reset", int'(stray), 0);
      if (s != 0) begin
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R8 irq cleared", irq, 0);
        wait_evt(0, j, stray);
        check("R7 repeat interval", j + 1, 2 * period_of(2'(s)));
      end
      clear_irq();
    end

    // R6 watchdog short tap
    wr({8'h5A, 8'h0B});
    wait_evt(1, j, stray);
    check("R5 R6 watchdog tap6", j, 64);
    check("R6 ctl reset", rd_data, 16'h6900);

    // R9 hold freezes counter
    wr({8'h5A, 8'h8B});
    repeat (200) @(negedge clk);
    check("R9 no expiry on hold", rst_req, 0);
    wr({8'h5A, 8'h03});
    wait_evt(1, j, stray);
    check("R9 full interval left", j, 64);

    // R10 clear restarts count
    wr({8'h5A, 8'h0B});
    repeat (40) @(negedge clk);
    wr({8'h5A, 8'h0B});
    wait_evt(1, j, stray);
    check("R10 restart after clear", j, 64);

    // R11 tick select
    wr({8'h5A, 8'h1F});
    repeat (200) @(negedge clk);
    check("R11 tick_a ignored", irq, 0);
    tick_b = 1'b1;
    wait_evt(0, j, stray);
    check("R11 tick_b count", j, 64);
    clear_irq();
    check("R8 irq clear", irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule